// File: doc/BRIEF.md
# Condition flag and bit unit

This execution unit owns the single condition flag of a small processor core. It takes an operation select, two register operand values (A and B) and a valid strobe. Test operations compare operands and load the flag. Single-bit operations build a one-hot mask from operand B and then set a bit in A, clear it, copy it into the flag, or set it only while the flag is true. Fetch, operand read and register write-back belong to the surrounding core. The unit returns the new register value with a write-enable, the flag itself, and a branch-taken decision for the two conditional jump forms.

Flag and result both update at the clock edge that samples a valid operation. The result and its write-enable are therefore visible one cycle after issue. An operation issued in the next cycle already sees the new flag. The branch decision is combinational from the current flag and the jump select, so the core can redirect fetch in the issue cycle. Nothing but an explicit test or a bit read changes the flag.

Top module: `cond_bit_unit`

## Requirements
- R1: While reset (`rstN` low) is asserted, and in the first cycle after release, `flag` is 0, `resWe` is 0 and `takeBranch` is 0.
- R2: A valid zero test with `opSel`=3 loads the flag with (A == 0). A valid nonzero test with `opSel`=4 loads it with (A != 0). Neither writes a result.
- R3: A valid ordered test with `opSel`=5 loads the flag with (B > A). The test with `opSel`=6 loads it with (B <= A). Both compare the operands as unsigned values and write no result.
- R4: A valid bit set with `opSel`=7 returns A OR (1 << B) with `resWe` high one cycle after issue.
- R5: A valid bit clear with `opSel`=8 returns A AND NOT (1 << B) with `resWe` high one cycle after issue.
- R6: A valid bit read with `opSel`=9 loads the flag with bit B of A and leaves `resWe` low.
- R7: A valid conditional bit set with `opSel`=10 returns A OR (1 << B) with `resWe` high when the flag is 1. When the flag is 0, `resWe` stays low, so the register is left unchanged.
- R8: A bit index B at or beyond DATA_W gives an all-zero mask. Bit set, bit clear and a flag-gated conditional bit set then return A unchanged, and a bit read loads 0 into the flag.
- R9: While `opValid` is high and `opSel` is 1 (absolute) or 2 (relative), `takeBranch` equals the current flag in the same cycle. It is 0 in every other case, and jumps write no result.
- R10: The flag keeps its value when `opValid` is low and for every select other than 3, 4, 5, 6 and 9, including unused codes 0 and 11 to 15. Those selects produce no write.
- R11: An operation issued in the cycle right after a flag-loading operation uses the newly loaded flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation strobe for this cycle |
| opSel | input | 4 | Operation select (codes given in the requirements) |
| regA | input | DATA_W | Operand A: value tested or modified |
| regB | input | DATA_W | Operand B: compare value or bit index |
| resValue | output | DATA_W | Updated register value, meaningful while resWe is high |
| resWe | output | 1 | Register write-enable, one cycle after issue |
| flag | output | 1 | Current condition flag |
| takeBranch | output | 1 | Conditional jump taken, same cycle as issue |

## Verification
Two functions meet at one clock edge: a test or bit read loads the flag, and a conditional bit set or conditional jump issued in the following cycle consumes it. The bench provokes this by issuing flag loaders and flag consumers back to back, with no idle cycle between them, in both flag polarities. A reference flag in the driver follows every issued operation in order. Each queued expectation, and each same-cycle branch decision, is judged against that reference, so a stale or early flag shows up as a wrong write or a wrong branch.

// File: rtl/cond_bit_pkg.sv
`timescale 1ns/1ps
package cond_bit_pkg;

  typedef enum logic [3:0] {
    OP_IDLE  = 4'd0,
    OP_JMPC  = 4'd1,
    OP_JRELC = 4'd2,
    OP_TZ    = 4'd3,
    OP_TNZ   = 4'd4,
    OP_TBGT  = 4'd5,
    OP_TBLE  = 4'd6,
    OP_BSET  = 4'd7,
    OP_BCLR  = 4'd8,
    OP_BGET  = 4'd9,
    OP_BPUT  = 4'd10
  } opKind_e;

  typedef enum logic [2:0] {
    FS_ZERO  = 3'd0,
    FS_NZERO = 3'd1,
    FS_BGTA  = 3'd2,
    FS_BLEA  = 3'd3,
    FS_BIT   = 3'd4
  } flagSrc_e;

  typedef struct packed {
    logic     flagLoad;
    flagSrc_e flagSrc;
    logic     wrReq;
    logic     wrNeedsFlag;
    logic     clearMask;
    logic     isJump;
  } ctrlStrobe_t;

endpackage

// File: rtl/cond_bit_ctrl.sv
`timescale 1ns/1ps
module cond_bit_ctrl
  import cond_bit_pkg::*;
(
  input  logic        opValid,
  input  logic [3:0]  opSel,
  output ctrlStrobe_t strobe
);

  opKind_e kind;

  always_comb begin
    kind   = opKind_e'(opSel);
    strobe = '0;
    strobe.flagSrc = FS_ZERO;
    if (opValid) begin
      unique case (kind)
        OP_JMPC, OP_JRELC: strobe.isJump = 1'b1;
        OP_TZ:   begin strobe.flagLoad = 1'b1; strobe.flagSrc = FS_ZERO;  end
        OP_TNZ:  begin strobe.flagLoad = 1'b1; strobe.flagSrc = FS_NZERO; end
        OP_TBGT: begin strobe.flagLoad = 1'b1; strobe.flagSrc = FS_BGTA;  end
        OP_TBLE: begin strobe.flagLoad = 1'b1; strobe.flagSrc = FS_BLEA;  end
        OP_BGET: begin strobe.flagLoad = 1'b1; strobe.flagSrc = FS_BIT;   end
        OP_BSET: strobe.wrReq = 1'b1;
        OP_BCLR: begin strobe.wrReq = 1'b1; strobe.clearMask = 1'b1; end
        OP_BPUT: begin strobe.wrReq = 1'b1; strobe.wrNeedsFlag = 1'b1; end
        default: strobe = strobe;
      endcase
    end
  end

endmodule

// File: rtl/cond_bit_datapath.sv
`timescale 1ns/1ps
module cond_bit_datapath
  import cond_bit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] regA,
  input  logic [DATA_W-1:0] regB,
  output logic [DATA_W-1:0] resValue,
  output logic              resWe,
  output logic              flag,
  output logic              takeBranch
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [DATA_W-1:0] IDX_LIMIT = DATA_W'(DATA_W);

  logic              flagQ;
  logic              idxInRange;
  logic [DATA_W-1:0] bitMask;
  logic              selBit;
  logic              nextFlag;
  logic              writeFire;
  logic [DATA_W-1:0] newValue;

  assign idxInRange = (regB < IDX_LIMIT);

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_mask
      assign bitMask[gi] = idxInRange && (regB[IDX_W-1:0] == IDX_W'(gi));
    end
  endgenerate

  assign selBit = |(regA & bitMask);

  always_comb begin
    unique case (strobe.flagSrc)
      FS_ZERO:  nextFlag = (regA == '0);
      FS_NZERO: nextFlag = (regA != '0);
      FS_BGTA:  nextFlag = (regB > regA);
      FS_BLEA:  nextFlag = (regB <= regA);
      FS_BIT:   nextFlag = selBit;
      default:  nextFlag = 1'b0;
    endcase
  end

  assign writeFire = strobe.wrReq && (!strobe.wrNeedsFlag || flagQ);
  assign newValue  = strobe.clearMask ? (regA & ~bitMask) : (regA | bitMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ    <= 1'b0;
      resWe    <= 1'b0;
      resValue <= '0;
    end else begin
      if (strobe.flagLoad) flagQ <= nextFlag;
      resWe <= writeFire;
      if (writeFire) resValue <= newValue;
    end
  end

  assign flag       = flagQ;
  assign takeBranch = strobe.isJump && flagQ;

endmodule

// File: rtl/cond_bit_unit.sv
`timescale 1ns/1ps
module cond_bit_unit
  import cond_bit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opSel,
  input  logic [DATA_W-1:0] regA,
  input  logic [DATA_W-1:0] regB,
  output logic [DATA_W-1:0] resValue,
  output logic              resWe,
  output logic              flag,
  output logic              takeBranch
);

  ctrlStrobe_t strobe;

  cond_bit_ctrl uCtrl (
    .opValid (opValid),
    .opSel   (opSel),
    .strobe  (strobe)
  );

  cond_bit_datapath #(.DATA_W(DATA_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .regA       (regA),
    .regB       (regB),
    .resValue   (resValue),
    .resWe      (resWe),
    .flag       (flag),
    .takeBranch (takeBranch)
  );

endmodule

// File: rtl/cond_bit_unit_chk.sv
`timescale 1ns/1ps
module cond_bit_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [3:0]        opSel,
  input logic [DATA_W-1:0] regA,
  input logic [DATA_W-1:0] regB,
  input logic [DATA_W-1:0] resValue,
  input logic              resWe,
  input logic              flag,
  input logic              takeBranch
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rstN) |-> (!flag && !resWe));

  assert_zero_test_R2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 4'd3) |=> (flag == ($past(regA) == '0)) && !resWe);

  assert_order_test_R3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 4'd5) |=> (flag == ($past(regB) > $past(regA))));

  assert_set_keeps_bits_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 4'd7) |=> resWe && ((resValue & $past(regA)) == $past(regA)));

  assert_read_no_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 4'd9) |=> !resWe);

  assert_put_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 4'd10 && !flag) |=> !resWe);

  assert_branch_needs_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    takeBranch |-> (flag && opValid));

  assert_flag_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(opValid && (opSel inside {4'd3, 4'd4, 4'd5, 4'd6, 4'd9})) |=> $stable(flag));

endmodule

bind cond_bit_unit cond_bit_unit_chk #(.DATA_W(DATA_W)) uChk (.*);

// File: tb/tb_cond_bit_unit.sv
`timescale 1ns/1ps
module tb_cond_bit_unit;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          opValid = 1'b0;
  logic [3:0]    opSel = 4'd0;
  logic [DW-1:0] regA = '0;
  logic [DW-1:0] regB = '0;
  logic [DW-1:0] resValue;
  logic          resWe;
  logic          flag;
  logic          takeBranch;

  always #10 clk = ~clk;

  cond_bit_unit #(.DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .regA(regA), .regB(regB), .resValue(resValue), .resWe(resWe),
    .flag(flag), .takeBranch(takeBranch)
  );

  typedef struct packed {
    logic          we;
    logic [DW-1:0] val;
    logic          fl;
  } expItem_t;

  expItem_t expQ[$];
  string    reqQ[$];
  int       checkCnt = 0;
  int       failCnt  = 0;
  logic     modelFlag = 1'b0;
  bit       finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] maskOf(input logic [DW-1:0] b);
    return (b < DW) ? (32'h1 << b[4:0]) : '0;
  endfunction

  task automatic issue(input logic [3:0] op, input logic [DW-1:0] a,
                       input logic [DW-1:0] b, input string req);
    expItem_t e;
    logic     oldFlag;
    logic     expBr;
    @(negedge clk);
    opValid = 1'b1; opSel = op; regA = a; regB = b;
    oldFlag = modelFlag;
    e.we = 1'b0; e.val = '0;
    case (op)
      4'd3:  modelFlag = (a == 0);
      4'd4:  modelFlag = (a != 0);
      4'd5:  modelFlag = (b > a);
      4'd6:  modelFlag = (b <= a);
      4'd9:  modelFlag = ((a & maskOf(b)) != 0);
      4'd7:  begin e.we = 1'b1; e.val = a | maskOf(b); end
      4'd8:  begin e.we = 1'b1; e.val = a & ~maskOf(b); end
      4'd10: begin e.we = oldFlag; e.val = a | maskOf(b); end
      default: ;
    endcase
    e.fl = modelFlag;
    expQ.push_back(e);
    reqQ.push_back(req);
    expBr = (op == 4'd1 || op == 4'd2) && oldFlag;
    #1;
    check(takeBranch == expBr, (op == 4'd1 || op == 4'd2) ? "R9" : req,
          "takeBranch", DW'(takeBranch), DW'(expBr));
  endtask

  task automatic idle(input logic [3:0] op, input logic [DW-1:0] a);
    @(negedge clk);
    opValid = 1'b0; opSel = op; regA = a; regB = '0;
    #1;
    check(takeBranch == 1'b0, "R9", "takeBranch idle", DW'(takeBranch), '0);
  endtask

  // monitor: one expectation per valid issue, judged after the edge
  always @(posedge clk) begin
    if (rstN && opValid) begin
      expItem_t e;
      string    r;
      #5;
      if (expQ.size() == 0) begin
        check(1'b0, "R10", "unexpected result", '0, '0);
      end else begin
        e = expQ.pop_front();
        r = reqQ.pop_front();
        check(resWe == e.we, r, "resWe", DW'(resWe), DW'(e.we));
        if (e.we) check(resValue == e.val, r, "resValue", resValue, e.val);
        check(flag == e.fl, r, "flag", DW'(flag), DW'(e.fl));
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog expired actual=%h expected=%h", 1'b0, 1'b1);
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    #15;
    check(flag == 1'b0 && resWe == 1'b0 && takeBranch == 1'b0, "R1", "reset outputs",
          {flag, resWe, takeBranch}, '0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(flag == 1'b0 && resWe == 1'b0, "R1", "after release", {flag, resWe}, '0);

    // zero / nonzero tests (R2)
    issue(4'd3, 32'd0, 32'd0, "R2");
    issue(4'd3, 32'd5, 32'd0, "R2");
    issue(4'd4, 32'd5, 32'd0, "R2");
    issue(4'd4, 32'd0, 32'd0, "R2");
    // ordered tests, unsigned (R3)
    issue(4'd5, 32'd3, 32'd7, "R3");
    issue(4'd5, 32'd7, 32'd3, "R3");
    issue(4'd5, 32'd9, 32'd9, "R3");
    issue(4'd6, 32'd9, 32'd9, "R3");
    issue(4'd6, 32'd2, 32'hFFFF_FFFF, "R3");
    issue(4'd5, 32'h8000_0000, 32'h7FFF_FFFF, "R3");
    // bit set / clear (R4, R5)
    issue(4'd7, 32'h10, 32'd3, "R4");
    issue(4'd7, 32'h0, 32'd31, "R4");
    issue(4'd7, 32'h8, 32'd3, "R4");
    issue(4'd8, 32'hFF, 32'd0, "R5");
    issue(4'd8, 32'hFFFF_FFFF, 32'd31, "R5");
    // bit read (R6)
    issue(4'd9, 32'h80, 32'd7, "R6");
    issue(4'd9, 32'h80, 32'd6, "R6");
    // conditional bit set with flag 0 then flag 1, back to back (R7, R11)
    issue(4'd10, 32'h1, 32'd4, "R7");
    issue(4'd3, 32'd0, 32'd0, "R11");
    issue(4'd10, 32'h1, 32'd4, "R11");
    issue(4'd9, 32'h1, 32'd1, "R11");
    issue(4'd10, 32'h0, 32'd2, "R11");
    // out-of-range index (R8)
    issue(4'd4, 32'd1, 32'd0, "R8");
    issue(4'd7, 32'h55, 32'd32, "R8");
    issue(4'd8, 32'h55, 32'd40, "R8");
    issue(4'd10, 32'h55, 32'hFFFF_FFFF, "R8");
    issue(4'd9, 32'hFFFF_FFFF, 32'd33, "R8");
    // jumps with flag 0, then 1 (R9, R11)
    issue(4'd1, 32'h0, 32'h0, "R9");
    issue(4'd2, 32'h0, 32'h0, "R9");
    issue(4'd3, 32'd0, 32'd0, "R11");
    issue(4'd1, 32'h3, 32'h0, "R11");
    issue(4'd2, 32'h0, 32'h0, "R9");
    // flag held: idle with loader select, unused codes, jumps (R10)
    idle(4'd4, 32'd0);
    idle(4'd3, 32'd7);
    issue(4'd0, 32'd0, 32'd0, "R10");
    issue(4'd11, 32'd0, 32'd0, "R10");
    issue(4'd15, 32'd5, 32'd5, "R10");
    issue(4'd1, 32'd0, 32'd0, "R10");
    issue(4'd5, 32'd4, 32'd1, "R3");
    idle(4'd6, 32'd0);
    issue(4'd12, 32'd0, 32'd0, "R10");
    issue(4'd2, 32'd0, 32'd0, "R10");

    @(negedge clk);
    opValid = 1'b0;
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R10", "queue drained", DW'(expQ.size()), '0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule